// File: doc/BRIEF.md
# Direct-Mapped Tag Classifier

This block models the tag side of a direct-mapped data cache of fixed word capacity, with no data array and no memory traffic. Its only job is to label a stream of word accesses as hits or misses. Each cycle it can take one access, made of a load/store flag and a byte address. It looks up the selected line's valid bit and stored tag, returns a registered hit/miss result, allocates the line on any miss, and bumps one of four saturating statistics counters.

The line size is a parameter. With one word per line the whole capacity becomes that many single-word lines. With more words per line the line count shrinks and the word-offset bits inside a line take no part in the lookup. This lets one access trace be replayed against several geometries, and the counters show the read and write behaviour of each one.

Top module: `dmc_trace_classifier`

## Requirements
- R1: After reset all four counters read zero and every line is invalid, so the first access to any line is a miss.
- R2: Address fields: the byte offset is bits [1:0]. With one word per line (1024 lines) the index is bits [11:2] and the tag is bits [31:12]. With four words per line (256 lines) the word offset is bits [3:2], the index is bits [11:4] and the tag is bits [31:12].
- R3: An aligned access hits exactly when the indexed line is valid and its stored tag equals the address tag.
- R4: Any aligned miss, read or write, sets the line valid and stores the address tag. After a write miss, every word of that line then hits.
- R5: An access is taken on a clock edge where acc_valid and acc_ready are both high. res_valid, res_hit, res_write and res_misalign describe it in the next cycle. An access in the very next cycle to the same line sees the updated tag.
- R6: Each aligned access raises exactly one counter: read hit, read miss, write hit or write miss. The counter moves on the same edge that registers the result.
- R7: Counters are CNT_W bits wide (32 by default) and hold at their all-ones value instead of wrapping.
- R8: An access with address bits [1:0] not zero returns res_misalign=1 and res_hit=0. It moves no counter and leaves the tag store unchanged.
- R9: An aligned access to a valid line whose stored tag differs is a miss and replaces the tag, so the line's previous block then misses.
- R10: acc_ready is low during reset, rises one cycle after reset is released, and then stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access present |
| acc_ready | output | 1 | Block can take an access |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_addr | input | ADDR_W | Byte address |
| res_valid | output | 1 | Result for the access taken last cycle |
| res_hit | output | 1 | That access hit |
| res_write | output | 1 | That access was a store |
| res_misalign | output | 1 | That access was misaligned |
| rd_hit_cnt | output | CNT_W | Read hits |
| rd_miss_cnt | output | CNT_W | Read misses |
| wr_hit_cnt | output | CNT_W | Write hits |
| wr_miss_cnt | output | CNT_W | Write misses |

## Verification
The assertions check the following on every cycle: the one-cycle link between acceptance and result, the ready behaviour after reset, that counters never decrease and at most one moves per cycle, that a misaligned access leaves every counter still, and that a read hit result advances the read-hit counter. Whether a given address really hits depends on the history of the tag store, and only the bench's reference model can show that. The same holds for whole-line allocation on a write miss with wide lines, for eviction on a tag conflict, and for counters holding at saturation.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
   typedef enum logic {
      ACC_LOAD  = 1'b0,
      ACC_STORE = 1'b1
   } acc_kind_e;

   typedef enum logic [1:0] {
      CNT_RD_HIT  = 2'd0,
      CNT_RD_MISS = 2'd1,
      CNT_WR_HIT  = 2'd2,
      CNT_WR_MISS = 2'd3
   } cnt_sel_e;

   localparam int unsigned NUM_CNT = 4;

   typedef struct packed {
      logic hit;
      logic store;
      logic misalign;
   } result_t;
endpackage

// File: rtl/dmc_addr_split.sv
module dmc_addr_split #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned IDX_W  = 10,
   parameter int unsigned OFF_W  = 0,
   localparam int unsigned LSB   = OFF_W + 2,
   localparam int unsigned TAG_W = ADDR_W - IDX_W - LSB
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [TAG_W-1:0]  tag,
   output logic [IDX_W-1:0]  idx,
   output logic              misalign
);
   assign misalign = |addr[1:0];
   assign idx      = addr[LSB+IDX_W-1:LSB];
   assign tag      = addr[ADDR_W-1:LSB+IDX_W];

   generate
      if (OFF_W == 0) begin : g_single_word
         // every address bit above the byte offset takes part in the lookup
      end else begin : g_multi_word
         logic unused_word_off;
         assign unused_word_off = ^addr[LSB-1:2];
      end
   endgenerate
endmodule

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
   parameter int unsigned LINES = 1024,
   parameter int unsigned TAG_W = 20,
   localparam int unsigned IDX_W = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             look_en,
   input  logic [IDX_W-1:0] look_idx,
   input  logic [TAG_W-1:0] look_tag,
   output logic             look_hit
);
   logic [LINES-1:0] line_vld;
   logic [TAG_W-1:0] line_tag [LINES];

   assign look_hit = line_vld[look_idx] && (line_tag[look_idx] == look_tag);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         line_vld <= '0;
      end else if (look_en && !look_hit) begin
         line_vld[look_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (look_en && !look_hit) begin
         line_tag[look_idx] <= look_tag;
      end
   end
endmodule

// File: rtl/dmc_sat_counter.sv
module dmc_sat_counter #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         bump,
   output logic [W-1:0] value
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         value <= '0;
      end else if (bump && (value != {W{1'b1}})) begin
         value <= value + 1'b1;
      end
   end
endmodule

// File: rtl/dmc_trace_classifier.sv
module dmc_trace_classifier
   import dmc_pkg::*;
#(
   parameter int unsigned ADDR_W         = 32,
   parameter int unsigned CAP_WORDS      = 1024,
   parameter int unsigned WORDS_PER_LINE = 1,
   parameter int unsigned CNT_W          = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   output logic              acc_ready,
   input  logic              acc_write,
   input  logic [ADDR_W-1:0] acc_addr,
   output logic              res_valid,
   output logic              res_hit,
   output logic              res_write,
   output logic              res_misalign,
   output logic [CNT_W-1:0]  rd_hit_cnt,
   output logic [CNT_W-1:0]  rd_miss_cnt,
   output logic [CNT_W-1:0]  wr_hit_cnt,
   output logic [CNT_W-1:0]  wr_miss_cnt
);
   localparam int unsigned LINES = CAP_WORDS / WORDS_PER_LINE;
   localparam int unsigned IDX_W = $clog2(LINES);
   localparam int unsigned OFF_W = $clog2(WORDS_PER_LINE);
   localparam int unsigned TAG_W = ADDR_W - IDX_W - OFF_W - 2;

   generate
      if ((WORDS_PER_LINE == 0) || ((WORDS_PER_LINE & (WORDS_PER_LINE - 1)) != 0)) begin : g_bad_line
         $error("WORDS_PER_LINE must be a power of two");
      end
      if ((CAP_WORDS & (CAP_WORDS - 1)) != 0 || CAP_WORDS < WORDS_PER_LINE) begin : g_bad_cap
         $error("CAP_WORDS must be a power of two no smaller than a line");
      end
      if (ADDR_W <= IDX_W + OFF_W + 2) begin : g_bad_addr
         $error("ADDR_W leaves no tag bits");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be at least 1");
      end
   endgenerate

   logic             rdy_q;
   logic             take;
   logic             aligned_take;
   logic [TAG_W-1:0] a_tag;
   logic [IDX_W-1:0] a_idx;
   logic             a_mis;
   logic             lk_hit;
   result_t          res_q;
   logic [NUM_CNT-1:0] bump;
   logic [CNT_W-1:0]   cnt_val [NUM_CNT];

   always_ff @(posedge clk) begin
      if (!rst_n) rdy_q <= 1'b0;
      else        rdy_q <= 1'b1;
   end
   assign acc_ready = rdy_q;

   assign take         = acc_valid && rdy_q;
   assign aligned_take = take && !a_mis;

   dmc_addr_split #(
      .ADDR_W (ADDR_W),
      .IDX_W  (IDX_W),
      .OFF_W  (OFF_W)
   ) u_split (
      .addr     (acc_addr),
      .tag      (a_tag),
      .idx      (a_idx),
      .misalign (a_mis)
   );

   dmc_tag_store #(
      .LINES (LINES),
      .TAG_W (TAG_W)
   ) u_tags (
      .clk      (clk),
      .rst_n    (rst_n),
      .look_en  (aligned_take),
      .look_idx (a_idx),
      .look_tag (a_tag),
      .look_hit (lk_hit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_q     <= '0;
      end else begin
         res_valid      <= take;
         res_q.hit      <= aligned_take && lk_hit;
         res_q.store    <= acc_write;
         res_q.misalign <= take && a_mis;
      end
   end

   assign res_hit      = res_q.hit;
   assign res_write    = res_q.store;
   assign res_misalign = res_q.misalign;

   always_comb begin
      bump = '0;
      if (aligned_take) begin
         unique case ({acc_write, lk_hit})
            2'b01:   bump[CNT_RD_HIT]  = 1'b1;
            2'b00:   bump[CNT_RD_MISS] = 1'b1;
            2'b11:   bump[CNT_WR_HIT]  = 1'b1;
            default: bump[CNT_WR_MISS] = 1'b1;
         endcase
      end
   end

   generate
      for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
         dmc_sat_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .bump  (bump[c]),
            .value (cnt_val[c])
         );
      end
   endgenerate

   assign rd_hit_cnt  = cnt_val[CNT_RD_HIT];
   assign rd_miss_cnt = cnt_val[CNT_RD_MISS];
   assign wr_hit_cnt  = cnt_val[CNT_WR_HIT];
   assign wr_miss_cnt = cnt_val[CNT_WR_MISS];
endmodule

module dmc_trace_classifier_chk #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned CNT_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_valid,
   input logic              acc_ready,
   input logic              acc_write,
   input logic [ADDR_W-1:0] acc_addr,
   input logic              res_valid,
   input logic              res_hit,
   input logic              res_write,
   input logic              res_misalign,
   input logic [CNT_W-1:0]  rd_hit_cnt,
   input logic [CNT_W-1:0]  rd_miss_cnt,
   input logic [CNT_W-1:0]  wr_hit_cnt,
   input logic [CNT_W-1:0]  wr_miss_cnt
);
   localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

   assert_taken_gives_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_ready) |=> res_valid);
   assert_no_spurious_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_valid && acc_ready) |=> !res_valid);
   assert_ready_stays_R10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> acc_ready);
   assert_misalign_no_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      res_misalign |-> (res_valid && !res_hit));
   assert_misalign_no_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_ready && (acc_addr[1:0] != 2'b00)) |=>
         ($stable(rd_hit_cnt) && $stable(rd_miss_cnt) && $stable(wr_hit_cnt) && $stable(wr_miss_cnt)));
   assert_counts_monotonic_R7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((rd_hit_cnt >= $past(rd_hit_cnt)) && (rd_miss_cnt >= $past(rd_miss_cnt)) &&
                (wr_hit_cnt >= $past(wr_hit_cnt)) && (wr_miss_cnt >= $past(wr_miss_cnt))));
   assert_one_counter_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ($countones({rd_hit_cnt != $past(rd_hit_cnt), rd_miss_cnt != $past(rd_miss_cnt),
                            wr_hit_cnt != $past(wr_hit_cnt), wr_miss_cnt != $past(wr_miss_cnt)}) <= 1));
   assert_read_moves_read_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_ready && (acc_addr[1:0] == 2'b00) && !acc_write &&
       (rd_hit_cnt != TOP) && (rd_miss_cnt != TOP)) |=>
         ((rd_hit_cnt != $past(rd_hit_cnt)) || (rd_miss_cnt != $past(rd_miss_cnt))));
   assert_read_hit_counted_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_hit && !res_write && ($past(rd_hit_cnt) != TOP)) |->
         (rd_hit_cnt != $past(rd_hit_cnt)));
endmodule

bind dmc_trace_classifier dmc_trace_classifier_chk #(
   .ADDR_W (ADDR_W),
   .CNT_W  (CNT_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .acc_valid    (acc_valid),
   .acc_ready    (acc_ready),
   .acc_write    (acc_write),
   .acc_addr     (acc_addr),
   .res_valid    (res_valid),
   .res_hit      (res_hit),
   .res_write    (res_write),
   .res_misalign (res_misalign),
   .rd_hit_cnt   (rd_hit_cnt),
   .rd_miss_cnt  (rd_miss_cnt),
   .wr_hit_cnt   (wr_hit_cnt),
   .wr_miss_cnt  (wr_miss_cnt)
);

// File: tb/dmc_trace_classifier_test.sv
`timescale 1ns/1ps
module dmc_trace_classifier_test;
   typedef struct {
      bit hit;
      bit store;
      bit mis;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic        acc_write = 1'b0;
   logic [31:0] acc_addr = '0;

   // wide-line instance with narrow counters
   logic        rdy4, rv4, rh4, rw4, rm4;
   logic [3:0]  c4 [4];
   // single-word instance with full counters
   logic        rdy1, rv1, rh1, rw1, rm1;
   logic [31:0] c1 [4];

   int tests = 0;
   int fails = 0;
   int cyc = 0;
   bit done = 1'b0;

   exp_t q4[$];
   exp_t q1[$];
   bit          v4 [256];
   logic [19:0] t4 [256];
   bit          v1 [1024];
   logic [19:0] t1 [1024];
   int          e4 [4];
   int          e1 [4];

   always #4 clk = ~clk;

   dmc_trace_classifier #(.WORDS_PER_LINE(4), .CNT_W(4)) uut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(rdy4),
      .acc_write(acc_write), .acc_addr(acc_addr), .res_valid(rv4), .res_hit(rh4),
      .res_write(rw4), .res_misalign(rm4), .rd_hit_cnt(c4[0]), .rd_miss_cnt(c4[1]),
      .wr_hit_cnt(c4[2]), .wr_miss_cnt(c4[3]));

   dmc_trace_classifier #(.WORDS_PER_LINE(1), .CNT_W(32)) uut1 (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(rdy1),
      .acc_write(acc_write), .acc_addr(acc_addr), .res_valid(rv1), .res_hit(rh1),
      .res_write(rw1), .res_misalign(rm1), .rd_hit_cnt(c1[0]), .rd_miss_cnt(c1[1]),
      .wr_hit_cnt(c1[2]), .wr_miss_cnt(c1[3]));

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // driver: computes the expected result from the requirements and queues it
   task automatic issue(input bit w, input logic [31:0] a);
      exp_t x4, x1;
      int i4, i1, k;
      logic [19:0] tg;
      bit h4, h1;
      x4.store = w; x1.store = w;
      if (a[1:0] != 2'b00) begin
         x4.hit = 0; x4.mis = 1; x1.hit = 0; x1.mis = 1;   // R8
      end else begin
         tg = a[31:12];                                   // R2 tag
         i4 = int'(a[11:4]);                              // R2 wide-line index
         i1 = int'(a[11:2]);                              // R2 single-word index
         h4 = v4[i4] && (t4[i4] == tg);                   // R3
         h1 = v1[i1] && (t1[i1] == tg);
         if (!h4) begin v4[i4] = 1; t4[i4] = tg; end      // R4, R9
         if (!h1) begin v1[i1] = 1; t1[i1] = tg; end
         k = (w ? 2 : 0) + (h4 ? 0 : 1); e4[k]++;         // R6
         k = (w ? 2 : 0) + (h1 ? 0 : 1); e1[k]++;
         x4.hit = h4; x4.mis = 0; x1.hit = h1; x1.mis = 0;
      end
      acc_valid = 1'b1; acc_write = w; acc_addr = a;
      q4.push_back(x4); q1.push_back(x1);
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      acc_valid = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   task automatic check_counts(input string req);
      for (int k = 0; k < 4; k++) begin
         int sat;
         sat = (e4[k] > 15) ? 15 : e4[k];                 // R7 saturation at 4 bits
         check(c4[k] == 4'(sat), req, $sformatf("wide-line counter %0d", k), c4[k], sat);
         check(c1[k] == 32'(e1[k]), req, $sformatf("single-word counter %0d", k), c1[k], e1[k]);
      end
      check(q4.size() == 0 && q1.size() == 0, "R5", "results outstanding",
            q4.size() + q1.size(), 0);
   endtask

   // monitor: pops expected items as results appear
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (rv4) begin
            if (q4.size() == 0) check(0, "R5", "unexpected wide-line result", 1, 0);
            else begin
               exp_t x;
               x = q4.pop_front();
               check(rh4 == x.hit, "R3", "wide-line hit", rh4, x.hit);
               check(rw4 == x.store, "R5", "wide-line store echo", rw4, x.store);
               check(rm4 == x.mis, "R8", "wide-line misalign", rm4, x.mis);
            end
         end
         if (rv1) begin
            if (q1.size() == 0) check(0, "R5", "unexpected single-word result", 1, 0);
            else begin
               exp_t x;
               x = q1.pop_front();
               check(rh1 == x.hit, "R3", "single-word hit", rh1, x.hit);
               check(rw1 == x.store, "R5", "single-word store echo", rw1, x.store);
               check(rm1 == x.mis, "R8", "single-word misalign", rm1, x.mis);
            end
         end
      end
   end

   always @(posedge clk) cyc++;

   initial begin
      wait (cyc > 100000);
      if (!done) begin
         done = 1'b1;
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] lfsr;
      repeat (3) @(negedge clk);
      // R1: reset state
      for (int k = 0; k < 4; k++) begin
         check(c4[k] == 0, "R1", "wide-line counter at reset", c4[k], 0);
         check(c1[k] == 0, "R1", "single-word counter at reset", c1[k], 0);
      end
      check(!rv4 && !rv1, "R1", "result valid in reset", rv4 | rv1, 0);
      check(!rdy4 && !rdy1, "R10", "ready in reset", rdy4 | rdy1, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(rdy4 && rdy1, "R10", "ready after reset", rdy4 & rdy1, 1);

      // R1 cold miss, R5 back-to-back hit on the same line
      issue(0, 32'h0000_1000);
      issue(0, 32'h0000_1000);
      // R2/R4: neighbouring word hits only with wide lines
      issue(0, 32'h0000_1004);
      issue(1, 32'h0000_100C);
      idle(2);
      check_counts("R6");

      // R4: write miss allocates whole line
      issue(1, 32'h0000_5028);
      issue(0, 32'h0000_5020);
      issue(0, 32'h0000_5024);
      issue(0, 32'h0000_502C);
      // R9: conflicting tag on same index evicts
      issue(1, 32'h0000_2008);
      issue(0, 32'h0000_1000);
      idle(2);
      check_counts("R9");

      // R8: misaligned access ignored, state untouched
      issue(0, 32'h0000_1002);
      issue(1, 32'h0000_3003);
      issue(0, 32'h0000_1000);
      idle(2);
      check_counts("R8");

      // R7: drive the narrow read-hit counter past its top value
      for (int n = 0; n < 20; n++) issue(0, 32'h0000_1000);
      idle(2);
      check(c4[0] == 4'hF, "R7", "wide-line read hits held at top", c4[0], 15);
      check_counts("R7");

      // mixed pseudo-random trace over a small set of lines and tags
      lfsr = 32'hACE1_2345;
      for (int n = 0; n < 300; n++) begin
         logic [31:0] a;
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         a = {18'd0, lfsr[13:12], 6'd0, lfsr[5:2], (lfsr[20:16] == 5'd0) ? lfsr[1:0] : 2'b00};
         issue(lfsr[24], a);
      end
      idle(3);
      check_counts("R4");

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule